// File: doc/BRIEF.md
# Two-Pin Pipeline State Demultiplexer

A processor core reports its instruction pipeline activity on two active-low status pins, and each pin is shared between two phases of every bus cycle. In the first phase the pins carry two events: that an instruction has started and that a prefetch has occurred. In the second phase they carry one of three outcomes: the pipeline was invalidated, it advanced, or exception processing began. The all-high code means that nothing happened in either phase. This block samples the pins on the system clock, together with a phase indicator. It turns the two samples of a bus cycle into five separate active-high flags and presents them all at once, so that a trace or debug unit can line them up with the address, data and control state of the same bus cycle.

The block holds the first-phase decode until the second-phase sample arrives. It then updates all five flags together and pulses a one-cycle frame strobe. Two first-phase samples in a row are a sequencing fault: the older sample is dropped and an error pulse is raised. While the core is halted for debug the pins carry no meaning. A freeze input clears every flag and drops any half-captured frame.

Top module: `pipe_state_demux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all seven outputs are 0 and no first-phase sample is pending.
- R2: A first-phase sample (phase_i = 0) with pins {stat_n_i[1], stat_n_i[0]} decodes as 00 = start and fetch, 01 = fetch only, 10 = start only, 11 = neither. The result appears on start_o/fetch_o when its frame completes.
- R3: A second-phase sample (phase_i = 1) with pins {stat_n_i[1], stat_n_i[0]} decodes as 00 = invalid, 01 = advance, 10 = exception, 11 = none. At most one of invalid_o, advance_o and exception_o is ever 1.
- R4: A second-phase sample taken at a clock edge while a first-phase sample is pending updates all five flags at that edge and sets frame_valid_o high for exactly that one following cycle.
- R5: Apart from the frame update of R4 and the clearing by freeze, the five flags keep their values.
- R6: A second-phase sample with no pending first-phase sample is ignored: there is no frame_valid_o pulse and no flag changes.
- R7: A first-phase sample taken while one is already pending replaces the older one. seq_err_o is high for the one cycle after that edge. A following second-phase sample uses the newer code.
- R8: A clock edge with freeze_i high clears all five flags, frame_valid_o and seq_err_o for the next cycle, discards any pending first-phase sample, and ignores the pins.
- R9: frame_valid_o and seq_err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock (processor output clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | 0 = first-phase sample, 1 = second-phase sample |
| stat_n_i | input | 2 | Multiplexed status pins, active low |
| freeze_i | input | 1 | High while the core is in debug halt |
| start_o | output | 1 | Instruction start flag |
| fetch_o | output | 1 | Prefetch flag |
| invalid_o | output | 1 | Pipeline invalidated flag |
| advance_o | output | 1 | Pipeline advance flag |
| exception_o | output | 1 | Exception processing flag |
| frame_valid_o | output | 1 | One-cycle pulse when a new frame of flags is presented |
| seq_err_o | output | 1 | One-cycle pulse on two first-phase samples in a row |

## Verification
The assertions assume that the phase indicator and pins are stable at each sampling edge and that freeze_i holds a defined level at every edge, including the edge that releases reset. They do not assume that phases alternate. Unpaired first-phase samples and orphan second-phase samples are treated as legal stimulus with defined results. The stimulus drives every input only on falling clock edges and keeps freeze_i low during reset. Besides alternating pairs, it deliberately injects repeated first phases, orphan second phases and freeze windows, so the properties run through their fault paths as well as the normal one.

// File: rtl/pipe_demux_pkg.sv
package pipe_demux_pkg;

  localparam int unsigned PIN_W = 2;

  typedef struct packed {
    logic start;
    logic fetch;
  } p1_flags_t;

  typedef struct packed {
    logic invalid;
    logic advance;
    logic exception;
  } p2_flags_t;

  // act[1] / act[0]: pin 1 / pin 0 asserted (active-high view)
  function automatic p1_flags_t decode_phase1(input logic [PIN_W-1:0] act);
    p1_flags_t f;
    f.start = act[0];
    f.fetch = act[1];
    return f;
  endfunction

  function automatic p2_flags_t decode_phase2(input logic [PIN_W-1:0] act);
    p2_flags_t f;
    f = '0;
    unique case (act)
      2'b11:   f.invalid   = 1'b1;
      2'b10:   f.advance   = 1'b1;
      2'b01:   f.exception = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
  parameter int unsigned NUM_PINS   = 2,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] asserted_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    if (ACTIVE_LOW) begin : g_inv
      assign asserted_o[g] = ~pins_i[g];
    end else begin : g_pass
      assign asserted_o[g] = pins_i[g];
    end
  end

endmodule

// File: rtl/phase1_holder.sv
module phase1_holder
  import pipe_demux_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      load_i,
  input  logic      consume_i,
  input  p1_flags_t dec_i,
  output logic      pending_o,
  output p1_flags_t held_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      held_o    <= '0;
    end else if (flush_i) begin
      pending_o <= 1'b0;
      held_o    <= '0;
    end else if (load_i) begin
      pending_o <= 1'b1;
      held_o    <= dec_i;
    end else if (consume_i) begin
      pending_o <= 1'b0;
    end
  end

endmodule

// File: rtl/cycle_assembler.sv
module cycle_assembler
  import pipe_demux_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      pair_done_i,
  input  logic      overrun_i,
  input  p1_flags_t p1_i,
  input  p2_flags_t p2_i,
  output p1_flags_t p1_o,
  output p2_flags_t p2_o,
  output logic      valid_o,
  output logic      err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_o    <= '0;
      p2_o    <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (flush_i) begin
      p1_o    <= '0;
      p2_o    <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= pair_done_i;
      err_o   <= overrun_i;
      if (pair_done_i) begin
        p1_o <= p1_i;
        p2_o <= p2_i;
      end
    end
  end

endmodule

// File: rtl/pipe_state_demux.sv
module pipe_state_demux
  import pipe_demux_pkg::*;
#(
  parameter bit ACTIVE_LOW   = 1'b1,
  parameter bit PHASE2_LEVEL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_i,
  input  logic [PIN_W-1:0] stat_n_i,
  input  logic             freeze_i,
  output logic             start_o,
  output logic             fetch_o,
  output logic             invalid_o,
  output logic             advance_o,
  output logic             exception_o,
  output logic             frame_valid_o,
  output logic             seq_err_o
);

  logic [PIN_W-1:0] act_w;
  p1_flags_t        p1_dec_w, p1_held_w, p1_q;
  p2_flags_t        p2_dec_w, p2_q;

  // named internal events, observed by the checker
  logic p1_sample_w, p2_sample_w, pend_w, pair_done_w, overrun_w;

  pin_conditioner #(.NUM_PINS(PIN_W), .ACTIVE_LOW(ACTIVE_LOW)) cond_i (
    .pins_i     (stat_n_i),
    .asserted_o (act_w)
  );

  assign p1_dec_w    = decode_phase1(act_w);
  assign p2_dec_w    = decode_phase2(act_w);
  assign p2_sample_w = !freeze_i && (phase_i == PHASE2_LEVEL);
  assign p1_sample_w = !freeze_i && (phase_i != PHASE2_LEVEL);
  assign pair_done_w = p2_sample_w && pend_w;
  assign overrun_w   = p1_sample_w && pend_w;

  phase1_holder hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (freeze_i),
    .load_i    (p1_sample_w),
    .consume_i (pair_done_w),
    .dec_i     (p1_dec_w),
    .pending_o (pend_w),
    .held_o    (p1_held_w)
  );

  cycle_assembler asm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (freeze_i),
    .pair_done_i (pair_done_w),
    .overrun_i   (overrun_w),
    .p1_i        (p1_held_w),
    .p2_i        (p2_dec_w),
    .p1_o        (p1_q),
    .p2_o        (p2_q),
    .valid_o     (frame_valid_o),
    .err_o       (seq_err_o)
  );

  assign start_o     = p1_q.start;
  assign fetch_o     = p1_q.fetch;
  assign invalid_o   = p2_q.invalid;
  assign advance_o   = p2_q.advance;
  assign exception_o = p2_q.exception;

endmodule

// File: rtl/pipe_state_demux_chk.sv
module pipe_state_demux_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic phase_i,
  input logic freeze_i,
  input logic start_o,
  input logic fetch_o,
  input logic invalid_o,
  input logic advance_o,
  input logic exception_o,
  input logic frame_valid_o,
  input logic seq_err_o,
  input logic pend_w,
  input logic p2_sample_w
);

  logic [4:0] flags;
  assign flags = {start_o, fetch_o, invalid_o, advance_o, exception_o};

  assert_p2_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({invalid_o, advance_o, exception_o}));

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  assert_valid_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> ($past(phase_i) && $past(pend_w) && !$past(freeze_i)));

  assert_flags_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_valid_o && !$past(freeze_i)) |-> $stable(flags));

  assert_orphan_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_sample_w && !pend_w) |=> !frame_valid_o);

  assert_err_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> (!$past(phase_i) && $past(pend_w) && !$past(freeze_i)));

  assert_freeze_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(freeze_i) |-> (flags == 5'b0 && !frame_valid_o && !seq_err_o));

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && seq_err_o));

endmodule

bind pipe_state_demux pipe_state_demux_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phase_i       (phase_i),
  .freeze_i      (freeze_i),
  .start_o       (start_o),
  .fetch_o       (fetch_o),
  .invalid_o     (invalid_o),
  .advance_o     (advance_o),
  .exception_o   (exception_o),
  .frame_valid_o (frame_valid_o),
  .seq_err_o     (seq_err_o),
  .pend_w        (pend_w),
  .p2_sample_w   (p2_sample_w)
);

// File: tb/pipe_state_demux_tb.sv
`timescale 1ns/1ps
module pipe_state_demux_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic [1:0] pins = 2'b11;
  logic       frz = 1'b0;
  logic st, fe, iv, ad, ex, vl, er;

  always #2 clk = ~clk;

  pipe_state_demux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .stat_n_i(pins),
    .freeze_i(frz), .start_o(st), .fetch_o(fe), .invalid_o(iv),
    .advance_o(ad), .exception_o(ex), .frame_valid_o(vl), .seq_err_o(er)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int pend_q[$];
  int e_st, e_fe, e_iv, e_ad, e_ex, e_vl, e_er;

  // lookup tables indexed by pin code {pin1,pin0}
  int p1_start[4] = '{1, 0, 1, 0};
  int p1_fetch[4] = '{1, 1, 0, 0};
  int p2_kind [4] = '{1, 2, 3, 0}; // 1 invalid, 2 advance, 3 exception, 0 none

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("start_o", st, e_st);
    chk("fetch_o", fe, e_fe);
    chk("invalid_o", iv, e_iv);
    chk("advance_o", ad, e_ad);
    chk("exception_o", ex, e_ex);
    chk("frame_valid_o", vl, e_vl);
    chk("seq_err_o", er, e_er);
    chk("R9 valid/err overlap", int'(vl && er), 0);
    chk("R3 phase-2 onehot", int'(iv) + int'(ad) + int'(ex) > 1, 0);
  endtask

  // model: expected outputs after the coming rising edge
  task automatic model(input bit r, input bit ph, input int code, input bit fz);
    if (!r || fz) begin
      pend_q.delete();
      {e_st, e_fe, e_iv, e_ad, e_ex, e_vl, e_er} = '0;
    end else if (!ph) begin
      e_er = (pend_q.size() > 0);
      pend_q.delete();
      pend_q.push_back(code);
      e_vl = 0;
    end else begin
      e_er = 0;
      if (pend_q.size() > 0) begin
        int c1 = pend_q.pop_front();
        e_st = p1_start[c1];
        e_fe = p1_fetch[c1];
        e_iv = (p2_kind[code] == 1);
        e_ad = (p2_kind[code] == 2);
        e_ex = (p2_kind[code] == 3);
        e_vl = 1;
      end else begin
        e_vl = 0;
      end
    end
  endtask

  task automatic step(input bit ph, input int code, input bit fz);
    @(negedge clk);
    compare_all();
    phase = ph;
    pins  = code[1:0];
    frz   = fz;
    model(rst_n, ph, code, fz);
  endtask

  initial begin
    model(1'b0, 1'b0, 3, 1'b0);
    // R1: reset values
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();
    model(1'b1, phase, int'(pins), frz);

    // R2/R3/R4: every phase-1 x phase-2 code pair
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        tag = "R2/R3/R4";
        step(1'b0, a, 1'b0);
        step(1'b1, b, 1'b0);
      end
    end

    // R5/R6: orphan second phases leave flags alone
    tag = "R5";
    step(1'b0, 0, 1'b0);
    step(1'b1, 2, 1'b0);
    tag = "R6";
    step(1'b1, 0, 1'b0);
    step(1'b1, 1, 1'b0);
    tag = "R5";
    step(1'b0, 3, 1'b0);
    step(1'b0, 3, 1'b0);

    // R7: repeated first phase, newer wins
    tag = "R7";
    step(1'b1, 3, 1'b0);
    step(1'b0, 0, 1'b0);
    step(1'b0, 2, 1'b0);
    step(1'b0, 1, 1'b0);
    step(1'b1, 1, 1'b0);
    step(1'b0, 1, 1'b0);

    // R8: freeze drops pending and clears flags
    tag = "R8";
    step(1'b0, 0, 1'b0);
    step(1'b1, 2, 1'b0);
    step(1'b0, 0, 1'b0);
    step(1'b1, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    step(1'b1, 0, 1'b0);
    step(1'b0, 1, 1'b0);
    step(1'b1, 0, 1'b0);

    // R9: random mix of all inputs
    tag = "R9";
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), $urandom_range(0, 3), ($urandom_range(0, 15) == 0));
    step(1'b1, 3, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule